// File: doc/BRIEF.md
# Self-Clocking Serial Byte Link

This block is a byte-wide asynchronous serial receiver and transmitter for a debug port whose baud rate is unknown at reset. After reset it watches the serial input for a single calibration character, the byte 0x80, sent by the host. It counts the clock cycles for which the line stays low during that character. That low span is the start bit plus seven zero data bits. The count divided by eight becomes the bit period for all later traffic.

Once calibrated, the block receives and sends frames made of one start bit, eight data bits sent least significant bit first, and one stop bit, with no parity. Received bytes appear on a byte output with a one-cycle strobe. A frame whose stop bit is sampled low is dropped and flagged with a one-cycle error pulse instead. Bytes to send enter through a valid/ready handshake. A status output shows whether the link has calibrated.

Top module: `autobaud_uart`

## Requirements
- R1: A frame received after calibration is sampled at the centre of each bit (half a bit period after the start edge, then one bit period apart). It yields `rxd_data` with the first data bit in bit 0 and a `rxd_valid` pulse one cycle wide.
- R2: Each transmitted frame is a low start bit, the eight data bits starting with bit 0, and a high stop bit. Each bit is held on `tx_o` for exactly one learned bit period, so `txd_ready` returns exactly ten bit periods after the accepting edge.
- R3: Until calibration completes, `locked` and `txd_ready` are low, `tx_o` is high, and no byte or error strobe is produced.
- R4: The bit period is the number of cycles the synchronized input stays low during the calibration character, shifted right by three. The cycle counter saturates instead of wrapping. The period never changes once `locked` is high.
- R5: A low pulse shorter than 8 cycles before calibration is rejected, and the block keeps waiting for a new calibration character.
- R6: `locked` rises only after the high remainder of the calibration character, two bit periods from its rising edge, has elapsed. It then stays high until reset.
- R7: A received frame whose stop bit samples low produces a one-cycle `rxd_ferr` pulse and no `rxd_valid`; the two strobes are never high together.
- R8: After calibration, a low pulse that has ended by the half-bit sample point is treated as a false start and produces no strobe.
- R9: `txd_ready` is high only while calibrated and no frame is being sent, and it drops in the cycle after a byte is accepted. `tx_o` is high between frames.
- R10: Reception and transmission run independently at the same time, both at the learned period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_i | input | 1 | Serial input from host, idles high |
| tx_o | output | 1 | Serial output to host, idles high |
| rxd_data | output | 8 | Last received byte |
| rxd_valid | output | 1 | One-cycle strobe: `rxd_data` holds a new byte |
| rxd_ferr | output | 1 | One-cycle strobe: frame dropped, stop bit was low |
| txd_data | input | 8 | Byte to transmit |
| txd_valid | input | 1 | `txd_data` is offered |
| txd_ready | output | 1 | Transmitter will accept a byte this cycle |
| locked | output | 1 | Calibration complete |

## Verification
The receiver finishing a frame and the transmitter shifting out bits can fall in the same cycle. Both count against the same learned period but keep separate counters and state. The bench provokes this by starting an incoming frame and an outgoing byte on the same clock edge after calibration. It judges the received byte and strobe count, and samples every outgoing bit at its centre. The result must match what each direction produces on its own.

// File: rtl/ab_pkg.sv
package ab_pkg;
  localparam int BYTE_W     = 8;
  localparam int FRAME_BITS = 10;
  localparam int MIN_SYNC   = 8;
  localparam int DIV_SHIFT  = 3;

  typedef enum logic [1:0] {L_WAIT, L_MEAS, L_TAIL, L_LOCK} learn_st_t;
  typedef enum logic [1:0] {R_IDLE, R_START, R_DATA, R_STOP} rx_st_t;
endpackage

// File: rtl/ab_sync.sv
module ab_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic line,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) chain[0] <= rst ? 1'b1 : din;
      end else begin : g_next
        always_ff @(posedge clk) chain[i] <= rst ? 1'b1 : chain[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) prev <= rst ? 1'b1 : chain[STAGES-1];

  assign line = chain[STAGES-1];
  assign fall = prev & ~chain[STAGES-1];
endmodule

// File: rtl/ab_learn.sv
module ab_learn
  import ab_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int PER_W = CNT_W - DIV_SHIFT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line,
  input  logic             fall,
  output logic [PER_W-1:0] period,
  output logic             locked
);
  learn_st_t        st;
  logic [CNT_W-1:0] meas;
  logic [PER_W:0]   tcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= L_WAIT;
      meas   <= '0;
      tcnt   <= '0;
      period <= '0;
      locked <= 1'b0;
    end else begin
      case (st)
        L_WAIT: if (fall) begin
          meas <= CNT_W'(1);
          st   <= L_MEAS;
        end
        L_MEAS: begin
          if (!line) begin
            if (meas != '1) meas <= meas + 1'b1;
          end else if (meas < CNT_W'(MIN_SYNC)) begin
            st <= L_WAIT;
          end else begin
            period <= meas[CNT_W-1:DIV_SHIFT];
            tcnt   <= '0;
            st     <= L_TAIL;
          end
        end
        L_TAIL: begin
          if ((tcnt + 1'b1) >= {period, 1'b0}) begin
            locked <= 1'b1;
            st     <= L_LOCK;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        default: st <= L_LOCK;
      endcase
    end
  end
endmodule

// File: rtl/ab_rx.sv
module ab_rx
  import ab_pkg::*;
#(
  parameter int PER_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              line,
  input  logic              fall,
  input  logic [PER_W-1:0]  period,
  output logic [BYTE_W-1:0] data,
  output logic              valid,
  output logic              ferr
);
  rx_st_t            st;
  logic [PER_W-1:0]  cnt;
  logic [PER_W:0]    cnt_nx;
  logic [2:0]        bitn;
  logic [BYTE_W-1:0] sh;
  logic              hit_half, hit_full;

  assign cnt_nx   = {1'b0, cnt} + 1'b1;
  assign hit_half = cnt_nx >= {2'b00, period[PER_W-1:1]};
  assign hit_full = cnt_nx >= {1'b0, period};

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= R_IDLE;
      cnt   <= '0;
      bitn  <= '0;
      sh    <= '0;
      data  <= '0;
      valid <= 1'b0;
      ferr  <= 1'b0;
    end else begin
      valid <= 1'b0;
      ferr  <= 1'b0;
      case (st)
        R_IDLE: if (en && fall) begin
          cnt <= '0;
          st  <= R_START;
        end
        R_START: begin
          if (hit_half) begin
            cnt  <= '0;
            bitn <= '0;
            st   <= line ? R_IDLE : R_DATA;
          end else cnt <= cnt + 1'b1;
        end
        R_DATA: begin
          if (hit_full) begin
            cnt  <= '0;
            sh   <= {line, sh[BYTE_W-1:1]};
            bitn <= bitn + 1'b1;
            if (bitn == 3'd7) st <= R_STOP;
          end else cnt <= cnt + 1'b1;
        end
        default: begin
          if (hit_full) begin
            if (line) begin
              data  <= sh;
              valid <= 1'b1;
            end else ferr <= 1'b1;
            st <= R_IDLE;
          end else cnt <= cnt + 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/ab_tx.sv
module ab_tx
  import ab_pkg::*;
#(
  parameter int PER_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [PER_W-1:0]  period,
  input  logic [BYTE_W-1:0] data,
  input  logic              valid,
  output logic              ready,
  output logic              txd
);
  logic [FRAME_BITS-1:0] sh;
  logic [PER_W-1:0]      cnt;
  logic [PER_W:0]        cnt_nx;
  logic [3:0]            bitn;
  logic                  busy;

  assign cnt_nx = {1'b0, cnt} + 1'b1;
  assign ready  = en & ~busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '1;
      cnt  <= '0;
      bitn <= '0;
      busy <= 1'b0;
      txd  <= 1'b1;
    end else if (!busy) begin
      if (valid && ready) begin
        sh   <= {1'b1, data, 1'b0};
        txd  <= 1'b0;
        cnt  <= '0;
        bitn <= '0;
        busy <= 1'b1;
      end
    end else if (cnt_nx >= {1'b0, period}) begin
      cnt <= '0;
      if (bitn == 4'(FRAME_BITS - 1)) begin
        busy <= 1'b0;
        txd  <= 1'b1;
      end else begin
        sh   <= {1'b1, sh[FRAME_BITS-1:1]};
        txd  <= sh[1];
        bitn <= bitn + 1'b1;
      end
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/autobaud_uart.sv
module autobaud_uart #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_i,
  output logic       tx_o,
  output logic [7:0] rxd_data,
  output logic       rxd_valid,
  output logic       rxd_ferr,
  input  logic [7:0] txd_data,
  input  logic       txd_valid,
  output logic       txd_ready,
  output logic       locked
);
  localparam int PER_W = CNT_W - ab_pkg::DIV_SHIFT;

  logic             line, fall;
  logic [PER_W-1:0] bit_period;

  ab_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(rx_i), .line(line), .fall(fall)
  );

  ab_learn #(.CNT_W(CNT_W)) u_learn (
    .clk(clk), .rst(rst), .line(line), .fall(fall),
    .period(bit_period), .locked(locked)
  );

  ab_rx #(.PER_W(PER_W)) u_rx (
    .clk(clk), .rst(rst), .en(locked), .line(line), .fall(fall),
    .period(bit_period), .data(rxd_data), .valid(rxd_valid), .ferr(rxd_ferr)
  );

  ab_tx #(.PER_W(PER_W)) u_tx (
    .clk(clk), .rst(rst), .en(locked), .period(bit_period),
    .data(txd_data), .valid(txd_valid), .ready(txd_ready), .txd(tx_o)
  );
endmodule

// File: rtl/ab_checker.sv
module ab_checker #(
  parameter int PER_W = 13
) (
  input logic             clk,
  input logic             rst,
  input logic             tx_o,
  input logic             rxd_valid,
  input logic             rxd_ferr,
  input logic             txd_valid,
  input logic             txd_ready,
  input logic             locked,
  input logic [PER_W-1:0] period
);
  AST_TX_IDLE_UNLOCKED: assert property (@(posedge clk) disable iff (rst)
    !locked |-> tx_o); // R3
  AST_NO_STROBE_UNLOCKED: assert property (@(posedge clk) disable iff (rst)
    !locked |-> !(rxd_valid || rxd_ferr)); // R3
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rxd_valid |=> !rxd_valid); // R1
  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(rxd_valid && rxd_ferr)); // R7
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
    locked |=> locked); // R6
  AST_PERIOD_FROZEN: assert property (@(posedge clk) disable iff (rst)
    locked |=> $stable(period)); // R4
  AST_READY_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
    txd_ready |-> locked); // R9
  AST_READY_DROPS: assert property (@(posedge clk) disable iff (rst)
    (txd_valid && txd_ready) |=> !txd_ready); // R9
endmodule

bind autobaud_uart ab_checker #(.PER_W(CNT_W - 3)) u_chk (
  .clk(clk), .rst(rst), .tx_o(tx_o), .rxd_valid(rxd_valid),
  .rxd_ferr(rxd_ferr), .txd_valid(txd_valid), .txd_ready(txd_ready),
  .locked(locked), .period(bit_period)
);

// File: tb/sim_autobaud_uart.sv
module sim_autobaud_uart;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_i = 1'b1;
  logic       tx_o;
  logic [7:0] rxd_data;
  logic       rxd_valid, rxd_ferr;
  logic [7:0] txd_data = 8'h00;
  logic       txd_valid = 1'b0;
  logic       txd_ready, locked;

  int checks = 0;
  int errors = 0;
  int bp = 16;
  int got_n = 0;
  int ferr_n = 0;
  logic [7:0] got_b = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  autobaud_uart u0 (
    .clk(clk), .rst(rst), .rx_i(rx_i), .tx_o(tx_o), .rxd_data(rxd_data),
    .rxd_valid(rxd_valid), .rxd_ferr(rxd_ferr), .txd_data(txd_data),
    .txd_valid(txd_valid), .txd_ready(txd_ready), .locked(locked)
  );

  always @(posedge clk) begin
    if (rxd_valid) begin got_n++; got_b = rxd_data; end
    if (rxd_ferr) ferr_n++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic line_bit(input logic b);
    rx_i = b;
    idle(bp);
  endtask

  task automatic send_frame(input logic [7:0] b, input logic stop);
    line_bit(1'b0);
    for (int i = 0; i < 8; i++) line_bit(b[i]);
    line_bit(stop);
    rx_i = 1'b1;
  endtask

  task automatic do_reset();
    rst = 1'b1; rx_i = 1'b1; txd_valid = 1'b0;
    idle(4);
    rst = 1'b0;
    idle(2);
    got_n = 0; ferr_n = 0;
  endtask

  task automatic do_sync(input int p);
    bp = p;
    send_frame(8'h80, 1'b1);
    idle(4);
    check(locked == 1'b1, "R6 locked after sync", int'(locked), 1);
    check(got_n == 0 && ferr_n == 0, "R3 no strobe from sync char", got_n + ferr_n, 0);
    idle(2 * bp);
  endtask

  task automatic t_reset();
    check(tx_o == 1'b1, "R3 tx idle at reset", int'(tx_o), 1);
    check(locked == 1'b0, "R3 not locked at reset", int'(locked), 0);
    check(txd_ready == 1'b0, "R3 ready low before sync", int'(txd_ready), 0);
  endtask

  task automatic t_short_reject();
    rx_i = 1'b0; idle(5); rx_i = 1'b1;
    idle(60);
    check(locked == 1'b0, "R5 short pulse rejected", int'(locked), 0);
    check(got_n == 0, "R3 no byte before sync", got_n, 0);
  endtask

  task automatic t_rx_byte(input logic [7:0] b);
    int n0 = got_n;
    send_frame(b, 1'b1);
    idle(bp);
    check(got_n == n0 + 1, "R1 one valid strobe", got_n - n0, 1);
    check(got_b == b, "R1 byte value", int'(got_b), int'(b));
  endtask

  task automatic t_ferr();
    int n0 = got_n;
    int f0 = ferr_n;
    send_frame(8'h5A, 1'b0);
    idle(2 * bp);
    check(ferr_n == f0 + 1, "R7 framing error pulse", ferr_n - f0, 1);
    check(got_n == n0, "R7 bad frame dropped", got_n - n0, 0);
  endtask

  task automatic t_false_start();
    int n0 = got_n + ferr_n;
    rx_i = 1'b0; idle(3); rx_i = 1'b1;
    idle(12 * bp);
    check(got_n + ferr_n == n0, "R8 false start ignored", got_n + ferr_n - n0, 0);
  endtask

  task automatic t_tx_bits(input logic [7:0] b, output int bad);
    logic [9:0] f;
    f = {1'b1, b, 1'b0};
    bad = 0;
    while (!txd_ready) @(negedge clk);
    txd_data = b; txd_valid = 1'b1;
    @(negedge clk);
    txd_valid = 1'b0;
    check(txd_ready == 1'b0, "R9 ready drops after accept", int'(txd_ready), 0);
    idle(bp / 2 - 1);
    for (int k = 0; k < 10; k++) begin
      if (tx_o !== f[k]) bad++;
      if (k < 9) idle(bp);
    end
  endtask

  task automatic t_tx_frame(input logic [7:0] b);
    int bad;
    t_tx_bits(b, bad);
    check(bad == 0, "R2 tx frame bits", bad, 0);
    idle(bp);
    check(tx_o == 1'b1 && txd_ready == 1'b1, "R9 idle high and ready", int'({tx_o, txd_ready}), 3);
  endtask

  task automatic t_tx_timing();
    int n = 0;
    while (!txd_ready) @(negedge clk);
    txd_data = 8'h00; txd_valid = 1'b1;
    @(negedge clk);
    txd_valid = 1'b0;
    while (!txd_ready && n < 20 * bp) begin @(negedge clk); n++; end
    check(n == 10 * bp, "R2 frame lasts ten periods", n, 10 * bp);
  endtask

  task automatic t_duplex();
    int bad;
    int n0 = got_n;
    fork
      send_frame(8'h96, 1'b1);
      t_tx_bits(8'h69, bad);
    join
    idle(2 * bp);
    check(bad == 0, "R10 tx bits during rx", bad, 0);
    check(got_n == n0 + 1 && got_b == 8'h96, "R10 rx byte during tx", int'(got_b), 8'h96);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    t_reset();
    t_short_reject();
    do_sync(16);
    check(txd_ready == 1'b1, "R9 ready after sync", int'(txd_ready), 1);
    t_rx_byte(8'hA5);
    t_rx_byte(8'h00);
    t_rx_byte(8'hFF);
    t_rx_byte(8'h3C);
    t_ferr();
    t_rx_byte(8'h81);
    t_false_start();
    t_tx_frame(8'hC3);
    t_tx_timing();
    t_duplex();
    // R4: recalibrate at a different rate after reset
    do_reset();
    t_reset();
    do_sync(24);
    t_rx_byte(8'h4E);
    t_tx_timing();
    t_tx_frame(8'h17);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule